// File: doc/BRIEF.md
# Page-Mode Byte Flash Model

This block is a synthesizable behavioural model of a byte-wide page-mode nonvolatile memory and the state machine that runs its internal write. A host drives active-low select, read and write strobes, an address and a data byte, all sampled on the block clock. Reads return array contents. Byte loads gather into a page buffer. When the host stops loading for a set number of cycles, the buffered page is committed to the array in one step, after an internal busy period.

While the internal cycle runs, reads return status instead of data. Bit 7 is the complement of the last loaded byte's bit 7, and bit 6 flips on every read, so the host can poll until the cycle ends. A short command sequence written to two fixed addresses turns on write protection. A longer sequence erases the whole array. Every timing constant is a parameter counted in clock cycles.

Top module: `pageflash`

## Requirements
- R1: `dout_en` is high exactly while `sel_n` and `rd_n` are both low. When no internal cycle is running, `dout` then shows the array byte at `addr`.
- R2: A byte load is active while `sel_n` and `wr_n` are both low. The address is taken in the first cycle the load is active, which is the later of the two falling strobes. The data is the `din` value in the last active cycle, which is the earlier of the two rising strobes.
- R3: `addr[PAGE_W-1:0]` selects the buffer slot and the upper address bits select the page. The page that is committed is the page of the last byte accepted.
- R4: A load phase continues while each new load starts within `LOAD_TO` cycles of the previous load ending. Once `LOAD_TO` idle cycles pass after the last load, the internal write begins.
- R5: A second load to a slot that is already filled replaces the earlier value.
- R6: The internal write lasts `WRITE_CYC` cycles and then writes the whole page at once. Slots that were never loaded are written as FFh.
- R7: While the write is busy, a read returns bit 7 = complement of bit 7 of the last loaded byte, bit 6 = a toggle that flips after every read, and bits 5:0 = bits 5:0 of that byte. Byte loads during the busy time are discarded. True data returns once the write completes.
- R8: The loads AAh@155h, 55h@2AAh, A0h@155h enable protection, which stays on until reset. These are the low 10 bits of 5555h and 2AAAh at the default width. Bytes that advance a command sequence are never stored. While protection is on, only the loads that follow a completed enable sequence are stored, up to the next internal write. Any other load is dropped and starts no write.
- R9: The loads AAh@155h, 55h@2AAh, 80h@155h, AAh@155h, 55h@2AAh, 10h@155h start an erase. During the erase, a read returns bit 7 = 0, bit 6 = toggle and bits 5:0 = 0. After `ERASE_CYC` cycles every array byte is FFh.
- R10: A load that does not match the next expected command step resets the sequence and is handled as an ordinary data load.
- R11: After reset, no internal cycle runs, protection is off and the bus is not driven. Array contents are unaffected by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Device select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status |
| dout_en | output | 1 | High when the block drives the data bus |

## Verification
The assertions check the following on every cycle:
- an internal write starts only from a load phase, after the strobes go idle;
- an erase starts only after a completed erase sequence;
- the page buffer stays frozen and the toggle bit moves only while the block is busy;
- protection never clears without reset.

The bench scenarios show the rest:
- the strobe-edge capture rules;
- slot replacement;
- FFh fill;
- commit to the last byte's page;
- sequence abort;
- the protected-drop rule, and the exact status bits seen by polling reads.

// File: rtl/pageflash_pkg.sv
package pageflash_pkg;
  typedef enum logic [1:0] {
    PF_IDLE  = 2'd0,
    PF_LOAD  = 2'd1,
    PF_PROG  = 2'd2,
    PF_ERASE = 2'd3
  } pf_state_e;

  localparam logic [15:0] PF_CMD_ADR1 = 16'h5555;
  localparam logic [15:0] PF_CMD_ADR2 = 16'h2AAA;
  localparam logic [7:0]  PF_K_UNLK1  = 8'hAA;
  localparam logic [7:0]  PF_K_UNLK2  = 8'h55;
  localparam logic [7:0]  PF_K_PROT   = 8'hA0;
  localparam logic [7:0]  PF_K_ERA    = 8'h80;
  localparam logic [7:0]  PF_K_ERAGO  = 8'h10;
endpackage

// File: rtl/pf_cmd_seq.sv
module pf_cmd_seq
  import pageflash_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              step,
  input  logic [ADDR_W-1:0] adr,
  input  logic [7:0]        dat,
  output logic              hit,
  output logic              prot_set,
  output logic              erase_go
);
  localparam logic [ADDR_W-1:0] A1 = PF_CMD_ADR1[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A2 = PF_CMD_ADR2[ADDR_W-1:0];

  logic [2:0] seq_q, seq_d, seq_adv;
  logic       is_prot, is_era;

  always_comb begin
    hit     = 1'b0;
    seq_adv = 3'd0;
    is_prot = 1'b0;
    is_era  = 1'b0;
    unique case (seq_q)
      3'd0: begin hit = (adr == A1) && (dat == PF_K_UNLK1); seq_adv = 3'd1; end
      3'd1: begin hit = (adr == A2) && (dat == PF_K_UNLK2); seq_adv = 3'd2; end
      3'd2: begin
        if (adr == A1 && dat == PF_K_PROT) begin
          hit = 1'b1; is_prot = 1'b1; seq_adv = 3'd0;
        end else if (adr == A1 && dat == PF_K_ERA) begin
          hit = 1'b1; seq_adv = 3'd3;
        end
      end
      3'd3: begin hit = (adr == A1) && (dat == PF_K_UNLK1); seq_adv = 3'd4; end
      3'd4: begin hit = (adr == A2) && (dat == PF_K_UNLK2); seq_adv = 3'd5; end
      3'd5: begin hit = (adr == A1) && (dat == PF_K_ERAGO); is_era = hit; seq_adv = 3'd0; end
      default: begin hit = 1'b0; seq_adv = 3'd0; end
    endcase
    prot_set = step && is_prot;
    erase_go = step && is_era;
    seq_d    = hit ? seq_adv : 3'd0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)   seq_q <= 3'd0;
    else if (step) seq_q <= seq_d;
  end
endmodule

// File: rtl/pf_page_buf.sv
module pf_page_buf #(
  parameter int PAGE_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_sn,
  input  logic                     wr_en,
  input  logic [PAGE_W-1:0]        off,
  input  logic [7:0]               wdat,
  input  logic                     clr,
  output logic [(1<<PAGE_W)*8-1:0] flat,
  output logic [(1<<PAGE_W)-1:0]   vld
);
  localparam int NB = 1 << PAGE_W;

  logic [7:0]    dat_q [NB];
  logic [NB-1:0] vld_q, vld_d;

  always_comb begin
    vld_d = vld_q;
    if (clr)        vld_d = '0;
    else if (wr_en) vld_d[off] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) vld_q <= '0;
    else         vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) dat_q[off] <= wdat;
  end

  for (genvar g = 0; g < NB; g++) begin : g_flat
    assign flat[g*8 +: 8] = dat_q[g];
  end

  assign vld = vld_q;
endmodule

// File: rtl/pf_ctrl.sv
module pf_ctrl
  import pageflash_pkg::*;
#(
  parameter int LOAD_TO   = 16,
  parameter int WRITE_CYC = 40,
  parameter int ERASE_CYC = 60
) (
  input  logic      clk,
  input  logic      rst_sn,
  input  logic      ld_act,
  input  logic      byte_in,
  input  logic      erase_go,
  output pf_state_e st,
  output logic      commit,
  output logic      wipe
);
  localparam int BMAX = (WRITE_CYC > ERASE_CYC) ? WRITE_CYC : ERASE_CYC;
  localparam int TW   = $clog2(LOAD_TO + 1);
  localparam int BW   = $clog2(BMAX + 1);

  pf_state_e st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [BW-1:0] bz_q, bz_d;

  always_comb begin
    st_d   = st_q;
    commit = 1'b0;
    wipe   = 1'b0;
    unique case (st_q)
      PF_IDLE: begin
        if (erase_go)     st_d = PF_ERASE;
        else if (byte_in) st_d = PF_LOAD;
      end
      PF_LOAD: begin
        if (erase_go) st_d = PF_ERASE;
        else if (!ld_act && tmr_q == TW'(LOAD_TO - 1)) st_d = PF_PROG;
      end
      PF_PROG: begin
        if (bz_q == BW'(WRITE_CYC - 1)) begin
          commit = 1'b1;
          st_d   = PF_IDLE;
        end
      end
      PF_ERASE: begin
        if (bz_q == BW'(ERASE_CYC - 1)) begin
          wipe = 1'b1;
          st_d = PF_IDLE;
        end
      end
      default: st_d = PF_IDLE;
    endcase
    tmr_d = (st_q == PF_LOAD && !ld_act) ? tmr_q + 1'b1 : '0;
    bz_d  = ((st_q == PF_PROG || st_q == PF_ERASE) && st_d == st_q) ? bz_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q  <= PF_IDLE;
      tmr_q <= '0;
      bz_q  <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      bz_q  <= bz_d;
    end
  end

  assign st = st_q;
endmodule

// File: rtl/pageflash.sv
module pageflash
  import pageflash_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 5,
  parameter int LOAD_TO   = 16,
  parameter int WRITE_CYC = 40,
  parameter int ERASE_CYC = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);
  localparam int NB  = 1 << PAGE_W;
  localparam int MB  = 1 << ADDR_W;
  localparam int PGW = ADDR_W - PAGE_W;

  logic [1:0] rs_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  logic ld_act, rd_act, ld_end, ld_start, rd_end;
  logic ld_act_q, rd_act_q;
  logic [ADDR_W-1:0] adr_q, adr_d;
  logic [7:0]        din_q, din_d;
  logic [6:0]        last_q, last_d;
  logic [PGW-1:0]    page_q, page_d;
  logic tog_q, tog_d, prot_q, prot_d, armed_q, armed_d;
  logic step, hit, prot_set, erase_go, accept, busy, loadable;
  logic commit, wipe;
  pf_state_e st;
  logic [NB*8-1:0] buf_flat;
  logic [NB-1:0]   buf_vld;
  logic [7:0]      mem [MB];

  assign ld_act   = !sel_n && !wr_n;
  assign rd_act   = !sel_n && !rd_n;
  assign ld_start = ld_act && !ld_act_q;
  assign ld_end   = ld_act_q && !ld_act;
  assign rd_end   = rd_act_q && !rd_act;
  assign busy     = (st == PF_PROG) || (st == PF_ERASE);
  assign loadable = (st == PF_IDLE) || (st == PF_LOAD);
  assign step     = ld_end && loadable;
  assign accept   = step && !hit && (!prot_q || armed_q);

  pf_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_sn(rst_sn), .step(step), .adr(adr_q), .dat(din_q),
    .hit(hit), .prot_set(prot_set), .erase_go(erase_go)
  );

  pf_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst_sn(rst_sn), .wr_en(accept), .off(adr_q[PAGE_W-1:0]),
    .wdat(din_q), .clr(commit | erase_go), .flat(buf_flat), .vld(buf_vld)
  );

  pf_ctrl #(.LOAD_TO(LOAD_TO), .WRITE_CYC(WRITE_CYC), .ERASE_CYC(ERASE_CYC)) u_ctrl (
    .clk(clk), .rst_sn(rst_sn), .ld_act(ld_act), .byte_in(accept),
    .erase_go(erase_go), .st(st), .commit(commit), .wipe(wipe)
  );

  always_comb begin
    adr_d   = ld_start ? addr : adr_q;
    din_d   = ld_act ? din : din_q;
    last_d  = accept ? {din_q[7], din_q[5:0]} : last_q;
    page_d  = accept ? adr_q[ADDR_W-1:PAGE_W] : page_q;
    tog_d   = (busy && rd_end) ? ~tog_q : tog_q;
    prot_d  = prot_q | prot_set;
    armed_d = prot_set ? 1'b1 : (busy ? 1'b0 : armed_q);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ld_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      adr_q    <= '0;
      din_q    <= '0;
      last_q   <= '0;
      page_q   <= '0;
      tog_q    <= 1'b0;
      prot_q   <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      ld_act_q <= ld_act;
      rd_act_q <= rd_act;
      adr_q    <= adr_d;
      din_q    <= din_d;
      last_q   <= last_d;
      page_q   <= page_d;
      tog_q    <= tog_d;
      prot_q   <= prot_d;
      armed_q  <= armed_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wipe) begin
      for (int i = 0; i < MB; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < NB; i++)
        mem[{page_q, PAGE_W'(i)}] <= buf_vld[i] ? buf_flat[i*8 +: 8] : 8'hFF;
    end
  end

  always_comb begin
    if (!rd_act)          dout = 8'h00;
    else if (st == PF_PROG)  dout = {~last_q[6], tog_q, last_q[5:0]};
    else if (st == PF_ERASE) dout = {1'b0, tog_q, 6'b0};
    else                  dout = mem[addr];
  end
  assign dout_en = rd_act;
endmodule

// File: rtl/pageflash_chk.sv
module pageflash_chk
  import pageflash_pkg::*;
#(
  parameter int NB = 32
) (
  input logic          clk,
  input logic          rst_sn,
  input pf_state_e     st,
  input logic          ld_act,
  input logic          erase_go,
  input logic [NB-1:0] buf_vld,
  input logic          tog_q,
  input logic          prot_q,
  input logic          busy
);
  AST_PROG_FROM_IDLE_LOAD: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(st == PF_PROG) |-> ($past(st) == PF_LOAD && !$past(ld_act))); // R4
  AST_ERASE_NEEDS_SEQ: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(st == PF_ERASE) |-> $past(erase_go)); // R9
  AST_BUF_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_sn)
    (st == PF_PROG && $past(st) == PF_PROG) |-> $stable(buf_vld)); // R7
  AST_TOGGLE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_sn)
    !$stable(tog_q) |-> $past(busy)); // R7
  AST_PROTECT_STICKY: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(prot_q) |-> prot_q); // R8
endmodule

bind pageflash pageflash_chk #(.NB(1 << PAGE_W)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .st(st), .ld_act(ld_act), .erase_go(erase_go),
  .buf_vld(buf_vld), .tog_q(tog_q), .prot_q(prot_q), .busy(busy)
);

// File: tb/pageflash_tb.sv
module pageflash_tb;
  localparam int AW = 10, PW = 5, LTO = 16, WCY = 40, ECY = 60;
  localparam int NV = 14;
  // {op[1:0], addr[15:0], data[7:0]}; op 0 = load, 1 = wait for write, 2 = read and compare
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 16'h0040, 8'h12}, {2'd0, 16'h0041, 8'h34}, {2'd0, 16'h0040, 8'h56},
    {2'd1, 16'h0000, 8'h00},
    {2'd2, 16'h0040, 8'h56}, {2'd2, 16'h0041, 8'h34}, {2'd2, 16'h0042, 8'hFF},
    {2'd2, 16'h005F, 8'hFF},
    {2'd0, 16'h0060, 8'h9A}, {2'd0, 16'h00A1, 8'h77},
    {2'd1, 16'h0000, 8'h00},
    {2'd2, 16'h00A0, 8'h9A}, {2'd2, 16'h00A1, 8'h77}, {2'd2, 16'h0060, 8'hFF}
  };

  logic clk, rst_n, sel_n, rd_n, wr_n, dout_en;
  logic [AW-1:0] addr;
  logic [7:0] din, dout;
  int n_tot, n_bad;
  bit finished;

  pageflash #(.ADDR_W(AW), .PAGE_W(PW), .LOAD_TO(LTO), .WRITE_CYC(WCY), .ERASE_CYC(ECY)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ld(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; sel_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk); sel_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] q, output logic en);
    @(negedge clk); addr = a; sel_n = 1'b0; rd_n = 1'b0;
    #2; q = dout; en = dout_en;
    @(negedge clk); sel_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic rdchk(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
    logic [7:0] q; logic en;
    rd(a, q, en);
    chk(tag, q, exp);
  endtask

  task automatic wait_write();
    wcyc(LTO + WCY + 8);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = '0; din = '0;
    wcyc(4); rst_n = 1'b1; wcyc(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_tot++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] q, q2; logic en;
    n_tot = 0; n_bad = 0; finished = 1'b0;
    do_reset();
    // R11 reset state: bus not driven
    #1; chk("R11 dout_en after reset", {7'd0, dout_en}, 8'h00);
    // R1 select alone or read alone does not drive the bus
    @(negedge clk); sel_n = 1'b0; #2; chk("R1 sel only", {7'd0, dout_en}, 8'h00);
    @(negedge clk); sel_n = 1'b1; rd_n = 1'b0; #2; chk("R1 rd only", {7'd0, dout_en}, 8'h00);
    @(negedge clk); rd_n = 1'b1;

    // R9 erase sequence, status while erasing, then all FF
    ld(10'h155, 8'hAA); ld(10'h2AA, 8'h55); ld(10'h155, 8'h80);
    ld(10'h155, 8'hAA); ld(10'h2AA, 8'h55); ld(10'h155, 8'h10);
    rd(10'h000, q, en);
    chk("R1 dout_en on read", {7'd0, en}, 8'h01);
    chk("R9 erase status bit7", {7'd0, q[7]}, 8'h00);
    rd(10'h000, q2, en);
    chk("R9 erase toggle bit6", {7'd0, q2[6]}, {7'd0, ~q[6]});
    wcyc(ECY + 5);
    rdchk("R9 erased low", 10'h000, 8'hFF);
    rdchk("R9 erased high", 10'h3FF, 8'hFF);

    // R3 R5 R6 table walk
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][25:24])
        2'd0: ld(VEC[i][8+AW-1:8], VEC[i][7:0]);
        2'd1: wait_write();
        default: rdchk("R3 R5 R6 table", VEC[i][8+AW-1:8], VEC[i][7:0]);
      endcase
    end

    // R7 busy status, toggle, loads discarded while busy
    ld(10'h100, 8'hC3);
    wcyc(LTO + 4);
    rd(10'h100, q, en);
    chk("R7 poll bit7 complement", {7'd0, q[7]}, 8'h00);
    chk("R7 poll low bits", {2'b0, q[5:0]}, 8'h03);
    rd(10'h100, q2, en);
    chk("R7 toggle bit6", {7'd0, q2[6]}, {7'd0, ~q[6]});
    ld(10'h101, 8'h11);
    wcyc(WCY + 5);
    rdchk("R7 true data after write", 10'h100, 8'hC3);
    rdchk("R7 busy load dropped", 10'h101, 8'hFF);

    // R4 load phase continues across a short gap
    ld(10'h120, 8'h01);
    wcyc(LTO - 4);
    ld(10'h121, 8'h02);
    wcyc(LTO - 4);
    rdchk("R4 still loading, array data", 10'h121, 8'hFF);
    wait_write();
    rdchk("R4 first byte kept", 10'h120, 8'h01);
    rdchk("R4 second byte kept", 10'h121, 8'h02);

    // R2 address at later falling strobe, data at earlier rising strobe
    @(negedge clk); sel_n = 1'b0; addr = 10'h150; din = 8'h00;
    @(negedge clk); wr_n = 1'b0; addr = 10'h140; din = 8'h55;
    @(negedge clk); addr = 10'h141; din = 8'h66;
    @(negedge clk); sel_n = 1'b1; wr_n = 1'b1;
    wait_write();
    rdchk("R2 captured addr and last data", 10'h140, 8'h66);
    rdchk("R2 later addr unused", 10'h141, 8'hFF);
    rdchk("R2 early addr unused", 10'h150, 8'hFF);

    // R10 aborted sequence: mismatching byte is data
    ld(10'h155, 8'hAA);
    ld(10'h1C0, 8'h3C);
    wait_write();
    rdchk("R10 abort byte stored", 10'h1C0, 8'h3C);
    rdchk("R10 command byte not stored", 10'h155, 8'hFF);

    // R8 protection enable, then guarded write, then plain write dropped
    ld(10'h155, 8'hAA); ld(10'h2AA, 8'h55); ld(10'h155, 8'hA0);
    ld(10'h180, 8'hAB);
    wait_write();
    rdchk("R8 guarded write", 10'h180, 8'hAB);
    rdchk("R8 cmd addr1 untouched", 10'h155, 8'hFF);
    rdchk("R8 cmd addr2 untouched", 10'h2AA, 8'hFF);
    ld(10'h1A0, 8'h12);
    wcyc(LTO + 5);
    rdchk("R8 plain write dropped, not busy", 10'h1A0, 8'hFF);

    // R11 reset clears protection, keeps array
    do_reset();
    rdchk("R11 array kept over reset", 10'h180, 8'hAB);
    ld(10'h1E0, 8'h5A);
    wait_write();
    rdchk("R11 unprotected after reset", 10'h1E0, 8'h5A);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule